// File: doc/BRIEF.md
# Three-Port Parallel I/O Interface

This block gives a host 24 general-purpose lines, grouped as three 8-bit ports called A, B and C. It has a small register-mapped bus with a 2-bit address, 8-bit write data, a registered read data path, and single-cycle read and write strobes. Each port drives its value out only when it is configured as an output. The block does not model pads: it presents output enables and leaves the tristate buffers outside. Port C has one enable per bit because its two nibbles can point in different directions, and in strobed mode its bits take separate roles.

A configuration word selects the direction of port A, port B and each half of port C. It also places group A (port A with the upper port C lines and bit 3) and group B (port B with bits 2:0) either in plain unstrobed I/O or in strobed handshake I/O. In strobed mode the group borrows port C lines. One line is the peripheral's strobe or acknowledge input. One is a buffer flag output. One is an interrupt request, which also appears on a dedicated output pin. A second kind of control write sets or clears any single port C latch bit. The same write sets the interrupt enables of the handshake groups.

Top module: `pio3_core`

## Requirements
- R1: After reset all ports are inputs and all groups are unstrobed: pa_oe, pb_oe, pc_oe and both interrupt outputs are 0, and reading address 3 returns 0x9B.
- R2: A write to address 3 with data bit 7 set loads the configuration. Bit 5 makes group A strobed, bit 4 makes port A an input, bit 3 makes port C bits 7:4 inputs, bit 2 makes group B strobed, bit 1 makes port B an input, and bit 0 makes port C bits 3:0 inputs. Bit 6 is ignored. The write clears the A, B and C output latches to zero. A read of address 3 returns bit 7 set, bit 6 clear, and bits 5:0 as written.
- R3: Addresses 0, 1 and 2 write the latches of ports A, B and C. The latch value always appears on pa_out, pb_out and pc_out (the last outside strobed roles). A read of an output port returns its latch. Read data is valid in the cycle after rd_stb.
- R4: A read of an unstrobed input port returns the value on its input pins, and that port's enable stays 0.
- R5: In unstrobed mode the two halves of port C follow separate direction bits. A read of port C returns, bit by bit, the latch for output bits and the pin value for input bits.
- R6: A write to address 3 with data bit 7 clear sets port C latch bit data[3:1] to data[0] and leaves the other bits unchanged.
- R7: Group A in strobed input mode uses port C bit 4 as the strobe input (active low) and bit 5 as the input-full output. Group B uses bit 2 as the strobe and bit 1 as the full flag. A falling strobe captures the port pins and sets the full flag. Later pin changes do not alter the captured value. Reading the port returns the captured value and clears the flag.
- R8: The group A interrupt (irq_a, also driven on port C bit 3) is high when its full flag is set and its enable is set. The enable is latch bit 4 in input mode and latch bit 6 in output mode. The group B interrupt (irq_b, port C bit 0) uses latch bit 2 as its enable.
- R9: In strobed output mode the full-bar line is port C bit 7 for group A and bit 1 for group B. A host write to the port drives that line low. A falling acknowledge (bit 6 for A, bit 2 for B) drives it high again and raises the group's interrupt if enabled. The next port write clears the interrupt.
- R10: In strobed mode the group's flag and interrupt bits are driven (enable 1) and its strobe or acknowledge bit is not (enable 0). All other port C bits keep their nibble's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wdata | input | 8 | Host write data |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C drive value |
| pc_oe | output | 8 | Port C per-bit output enable |
| irq_a | output | 1 | Group A interrupt request |
| irq_b | output | 1 | Group B interrupt request |

## Verification
The hardest case to reach is an interrupt that depends on three pieces of state set up in order: a strobed configuration, an enable written through a port C bit operation, and a handshake edge on a port C pin. The stimulus first raises the full flag with the enable clear, so the bench sees the flag without an interrupt. It then sets the enable through the bit operation and confirms the interrupt rises. Only after that does a read or write clear both. To confirm that the strobe latched the data, the pins are changed before the read.

// File: rtl/pio3_pkg.sv
package pio3_pkg;
  localparam int PIO_W   = 8;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADR_A   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_B   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_C   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTL = 2'd3;

  // port C roles in strobed mode
  localparam int PC_IRQ_B  = 0;
  localparam int PC_FLAG_B = 1;
  localparam int PC_HS_B   = 2;
  localparam int PC_IRQ_A  = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_IBF_A  = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OBF_A  = 7;

  typedef struct packed {
    logic a_strb;
    logic a_in;
    logic cu_in;
    logic b_strb;
    logic b_in;
    logic cl_in;
  } pio3_cfg_t;

  localparam pio3_cfg_t CFG_RESET = '{a_strb: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                      b_strb: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic pio3_cfg_t cfg_decode(input logic [PIO_W-1:0] d);
    pio3_cfg_t c;
    c.a_strb = d[5];
    c.a_in   = d[4];
    c.cu_in  = d[3];
    c.b_strb = d[2];
    c.b_in   = d[1];
    c.cl_in  = d[0];
    return c;
  endfunction

  function automatic logic [PIO_W-1:0] cfg_encode(input pio3_cfg_t c);
    return {2'b10, c.a_strb, c.a_in, c.cu_in, c.b_strb, c.b_in, c.cl_in};
  endfunction
endpackage

// File: rtl/pio3_sync.sv
module pio3_sync #(
  parameter int W = 8,
  parameter int STAGES = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pio3_hs.sv
module pio3_hs (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic dir_in,
  input  logic evt,
  input  logic rd,
  input  logic wr,
  output logic full,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full <= 1'b0;
      pend <= 1'b0;
    end else if (en) begin
      if (dir_in) begin
        if (evt) begin
          full <= 1'b1;
          pend <= 1'b1;
        end else if (rd) begin
          full <= 1'b0;
          pend <= 1'b0;
        end
      end else begin
        if (wr) begin
          full <= 1'b1;
          pend <= 1'b0;
        end else if (evt) begin
          full <= 1'b0;
          pend <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pio3_core.sv
module pio3_core
  import pio3_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIO_W-1:0]  wdata,
  input  logic              wr_stb,
  input  logic              rd_stb,
  output logic [PIO_W-1:0]  rdata,
  input  logic [PIO_W-1:0]  pa_in,
  output logic [PIO_W-1:0]  pa_out,
  output logic              pa_oe,
  input  logic [PIO_W-1:0]  pb_in,
  output logic [PIO_W-1:0]  pb_out,
  output logic              pb_oe,
  input  logic [PIO_W-1:0]  pc_in,
  output logic [PIO_W-1:0]  pc_out,
  output logic [PIO_W-1:0]  pc_oe,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int HALF = PIO_W / 2;

  pio3_cfg_t        cfg_q;
  logic [PIO_W-1:0] a_lat, b_lat, c_lat, a_cap, b_cap;
  logic [PIO_W-1:0] pa_s, pb_s, pc_s, pc_prev, pc_fall;
  logic [PIO_W-1:0] pc_drv, pc_en, pc_rd;
  logic             wr_ctl, mode_wr, bsr_wr;
  logic             wr_a, wr_b, rd_a, rd_b;
  logic             evt_a, evt_b, full_a, full_b, pend_a, pend_b;
  logic             inte_a, inte_b, irq_a_w, irq_b_w;

  pio3_sync #(.W(PIO_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_a (
    .clk(clk), .rst(rst), .d(pa_in), .q(pa_s));
  pio3_sync #(.W(PIO_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_b (
    .clk(clk), .rst(rst), .d(pb_in), .q(pb_s));
  pio3_sync #(.W(PIO_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_c (
    .clk(clk), .rst(rst), .d(pc_in), .q(pc_s));

  assign wr_ctl  = wr_stb && (addr == ADR_CTL);
  assign mode_wr = wr_ctl && wdata[PIO_W-1];
  assign bsr_wr  = wr_ctl && !wdata[PIO_W-1];
  assign wr_a    = wr_stb && (addr == ADR_A);
  assign wr_b    = wr_stb && (addr == ADR_B);
  assign rd_a    = rd_stb && (addr == ADR_A);
  assign rd_b    = rd_stb && (addr == ADR_B);

  assign pc_fall = pc_prev & ~pc_s;
  assign evt_a   = cfg_q.a_in ? pc_fall[PC_STB_A] : pc_fall[PC_ACK_A];
  assign evt_b   = pc_fall[PC_HS_B];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_RESET;
      a_lat   <= '0;
      b_lat   <= '0;
      c_lat   <= '0;
      pc_prev <= '1;
    end else begin
      pc_prev <= pc_s;
      if (mode_wr) begin
        cfg_q <= cfg_decode(wdata);
        a_lat <= '0;
        b_lat <= '0;
        c_lat <= '0;
      end else begin
        if (bsr_wr)                 c_lat[wdata[3:1]] <= wdata[0];
        if (wr_a)                   a_lat <= wdata;
        if (wr_b)                   b_lat <= wdata;
        if (wr_stb && addr == ADR_C) c_lat <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap <= '0;
      b_cap <= '0;
    end else begin
      if (evt_a && cfg_q.a_strb && cfg_q.a_in) a_cap <= pa_s;
      if (evt_b && cfg_q.b_strb && cfg_q.b_in) b_cap <= pb_s;
    end
  end

  pio3_hs u_hs_a (
    .clk(clk), .rst(rst), .clr(mode_wr), .en(cfg_q.a_strb), .dir_in(cfg_q.a_in),
    .evt(evt_a), .rd(rd_a), .wr(wr_a), .full(full_a), .pend(pend_a));
  pio3_hs u_hs_b (
    .clk(clk), .rst(rst), .clr(mode_wr), .en(cfg_q.b_strb), .dir_in(cfg_q.b_in),
    .evt(evt_b), .rd(rd_b), .wr(wr_b), .full(full_b), .pend(pend_b));

  assign inte_a  = cfg_q.a_in ? c_lat[PC_STB_A] : c_lat[PC_ACK_A];
  assign inte_b  = c_lat[PC_HS_B];
  assign irq_a_w = cfg_q.a_strb && pend_a && inte_a;
  assign irq_b_w = cfg_q.b_strb && pend_b && inte_b;

  always_comb begin
    pc_drv = c_lat;
    pc_en  = {{HALF{~cfg_q.cu_in}}, {HALF{~cfg_q.cl_in}}};
    if (cfg_q.b_strb) begin
      pc_en[PC_IRQ_B]  = 1'b1;
      pc_drv[PC_IRQ_B] = irq_b_w;
      pc_en[PC_FLAG_B] = 1'b1;
      pc_drv[PC_FLAG_B] = cfg_q.b_in ? full_b : ~full_b;
      pc_en[PC_HS_B]   = 1'b0;
    end
    if (cfg_q.a_strb) begin
      pc_en[PC_IRQ_A]  = 1'b1;
      pc_drv[PC_IRQ_A] = irq_a_w;
      if (cfg_q.a_in) begin
        pc_en[PC_STB_A]  = 1'b0;
        pc_en[PC_IBF_A]  = 1'b1;
        pc_drv[PC_IBF_A] = full_a;
      end else begin
        pc_en[PC_ACK_A]  = 1'b0;
        pc_en[PC_OBF_A]  = 1'b1;
        pc_drv[PC_OBF_A] = ~full_a;
      end
    end
  end

  assign pc_rd = (pc_en & pc_drv) | (~pc_en & pc_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_stb) begin
      unique case (addr)
        ADR_A:   rdata <= !cfg_q.a_in ? a_lat : (cfg_q.a_strb ? a_cap : pa_s);
        ADR_B:   rdata <= !cfg_q.b_in ? b_lat : (cfg_q.b_strb ? b_cap : pb_s);
        ADR_C:   rdata <= pc_rd;
        default: rdata <= cfg_encode(cfg_q);
      endcase
    end
  end

  assign pa_out = a_lat;
  assign pa_oe  = ~cfg_q.a_in;
  assign pb_out = b_lat;
  assign pb_oe  = ~cfg_q.b_in;
  assign pc_out = pc_drv;
  assign pc_oe  = pc_en;
  assign irq_a  = irq_a_w;
  assign irq_b  = irq_b_w;
endmodule

// File: rtl/pio3_core_chk.sv
module pio3_core_chk
  import pio3_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [PIO_W-1:0]  wdata,
  input logic              wr_stb,
  input logic [PIO_W-1:0]  pa_out,
  input logic [PIO_W-1:0]  pb_out,
  input logic              pa_oe,
  input logic              pb_oe,
  input logic [PIO_W-1:0]  pc_out,
  input logic [PIO_W-1:0]  pc_oe,
  input logic              irq_a,
  input logic              irq_b,
  input pio3_cfg_t         cfg,
  input logic              evt_a,
  input logic [PIO_W-1:0]  c_lat
);
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      // R1
      reset_quiet_chk: assert (!pa_oe && !pb_oe && pc_oe == '0 && !irq_a && !irq_b);
    end
  end

  // R2
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && addr == ADR_CTL && wdata[PIO_W-1]) |=> (pa_out == '0 && pb_out == '0));

  // R6
  bit_op_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && addr == ADR_CTL && !wdata[PIO_W-1]) |=> (c_lat[$past(wdata[3:1])] == $past(wdata[0])));

  // R7
  ibf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.a_strb && cfg.a_in && evt_a && !wr_stb) |=> pc_out[PC_IBF_A]);

  // R9
  obf_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.a_strb && !cfg.a_in && wr_stb && addr == ADR_A) |=> !pc_out[PC_OBF_A]);

  // R8
  irq_pin_chk: assert property (@(posedge clk) disable iff (rst)
    irq_b |-> (pc_oe[PC_IRQ_B] && pc_out[PC_IRQ_B]));
endmodule

bind pio3_core pio3_core_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_stb(wr_stb),
  .pa_out(pa_out), .pb_out(pb_out), .pa_oe(pa_oe), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe), .irq_a(irq_a), .irq_b(irq_b),
  .cfg(cfg_q), .evt_a(evt_a), .c_lat(c_lat));

// File: tb/pio3_core_bench.sv
`timescale 1ns/1ps
module pio3_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] rdata, pa_out, pb_out, pc_out, pc_oe;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = 8'hFF;
  logic       pa_oe, pb_oe, irq_a, irq_b;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pio3_core u_pio3_core (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe), .irq_a(irq_a), .irq_b(irq_b));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_c(input int bitn);
    pc_in[bitn] = 1'b0; idle(3);
    pc_in[bitn] = 1'b1; idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, p, exp, word, acc;
    idle(4); rst = 1'b0; idle(1);
    // R1 reset state
    check("R1 oe", {6'd0, pa_oe, pb_oe}, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 irq", {6'd0, irq_a, irq_b}, 8'h00);
    rd(2'd3, r); check("R1 ctl", r, 8'h9B);

    // R2 R3 R4 R5: every direction combination in unstrobed mode
    for (int m = 0; m < 16; m++) begin
      logic ai, cu, bi, cl;
      {ai, cu, bi, cl} = m[3:0];
      word = 8'h80 | {3'b0, ai, cu, 1'b0, bi, cl} | ((m % 2) ? 8'h40 : 8'h00);
      wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
      wr(2'd3, word);
      check("R2 clear a", pa_out, 8'h00);
      check("R2 clear b", pb_out, 8'h00);
      check("R2 clear c", pc_out, 8'h00);
      check("R2 oe", {6'd0, pa_oe, pb_oe}, {6'd0, ~ai, ~bi});
      check("R5 pc_oe", pc_oe, {{4{~cu}}, {4{~cl}}});
      rd(2'd3, r); check("R2 ctl read", r, word & 8'hBF);
      for (int k = 0; k < 3; k++) begin
        p = 8'h5A ^ (8'h33 * k[7:0]) ^ m[7:0];
        wr(2'd0, p); wr(2'd1, ~p); wr(2'd2, p + 8'd7);
        pa_in = ~p; pb_in = p ^ 8'h0F; pc_in = {p[3:0], p[7:4]};
        idle(2);
        check("R3 pa_out", pa_out, p);
        check("R3 pc_out", pc_out, p + 8'd7);
        rd(2'd0, r); check(ai ? "R4 read a" : "R3 read a", r, ai ? ~p : p);
        rd(2'd1, r); check(bi ? "R4 read b" : "R3 read b", r, bi ? (p ^ 8'h0F) : ~p);
        exp[7:4] = cu ? pc_in[7:4] : (p[7:0] + 8'd7) >> 4;
        exp[3:0] = cl ? pc_in[3:0] : (p[3:0] + 4'd7);
        rd(2'd2, r); check("R5 read c", r, exp);
      end
    end
    pc_in = 8'hFF; idle(3);

    // R6 single-bit set then clear on all output port C
    wr(2'd3, 8'h80);
    acc = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wr(2'd3, {4'b0, i[2:0], 1'b1}); acc[i] = 1'b1;
      check("R6 set", pc_out, acc);
    end
    for (int i = 7; i >= 0; i -= 2) begin
      wr(2'd3, {4'b0, i[2:0], 1'b0}); acc[i] = 1'b0;
      check("R6 clear", pc_out, acc);
    end

    // R7 R8 R10 strobed input on both groups
    wr(2'd3, 8'hB6);
    check("R10 in oe", pc_oe, 8'hEB);
    pa_in = 8'h3C; idle(2);
    pulse_c(4);
    check("R7 ibf a", {7'd0, pc_out[5]}, 8'h01);
    check("R8 no enable a", {7'd0, irq_a}, 8'h00);
    wr(2'd3, 8'h09);
    check("R8 irq a", {6'd0, irq_a, pc_out[3]}, 8'h03);
    pa_in = 8'h00; idle(2);
    rd(2'd0, r); check("R7 captured a", r, 8'h3C);
    check("R7 ibf a clear", {7'd0, pc_out[5]}, 8'h00);
    check("R8 irq a clear", {7'd0, irq_a}, 8'h00);
    pb_in = 8'hA5; idle(2);
    pulse_c(2);
    check("R7 ibf b", {7'd0, pc_out[1]}, 8'h01);
    check("R8 no enable b", {7'd0, irq_b}, 8'h00);
    wr(2'd3, 8'h05);
    check("R8 irq b", {6'd0, irq_b, pc_out[0]}, 8'h03);
    pb_in = 8'h5A; idle(2);
    rd(2'd1, r); check("R7 captured b", r, 8'hA5);
    check("R8 irq b clear", {6'd0, irq_b, pc_out[1]}, 8'h00);

    // R9 R10 strobed output on both groups
    wr(2'd3, 8'hA4);
    check("R10 out oe", pc_oe, 8'hBB);
    check("R9 obf idle", {6'd0, pc_out[7], pc_out[1]}, 8'h03);
    wr(2'd0, 8'h77);
    check("R9 data a", pa_out, 8'h77);
    check("R9 obf a low", {7'd0, pc_out[7]}, 8'h00);
    wr(2'd3, 8'h0D);
    check("R9 no irq yet", {7'd0, irq_a}, 8'h00);
    pulse_c(6);
    check("R9 ack a", {6'd0, pc_out[7], irq_a}, 8'h03);
    wr(2'd0, 8'h12);
    check("R9 rewrite a", {6'd0, pc_out[7], irq_a}, 8'h00);
    wr(2'd1, 8'h11);
    check("R9 obf b low", {7'd0, pc_out[1]}, 8'h00);
    wr(2'd3, 8'h05);
    pulse_c(2);
    check("R9 ack b", {6'd0, pc_out[1], irq_b}, 8'h03);
    wr(2'd1, 8'h22);
    check("R9 rewrite b", {6'd0, pc_out[1], irq_b}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule